// File: doc/BRIEF.md
# Host-Firmware Command Mailbox

This block is the device-side mailbox that lets a host processor, talking over a simple register bus, hand commands to an embedded firmware core and collect the answers. The host fills up to eight 16-bit payload registers, then writes one command word. The mailbox latches that word, sends a one-cycle request to the firmware side, and keeps a status word that moves through a fixed set of 4-bit state codes while the command is in flight. The firmware acknowledges the request, may read and rewrite the payload registers, and finally reports a result code and a response byte count.

Every command carries a parity flag that the host flips from one command to the next. The mailbox echoes this flag in the status word, together with the command's opcode. The host treats a command as finished once the echoed flag equals the flag it sent and the state code is no longer transient (received, processing or busy). A no-operation command is answered by the mailbox itself, which lets the host resynchronise its parity without involving the firmware. Values written back by the firmware are cleaned up before the host sees them, so a bad response size or a transient code can never leave the host waiting for ever or reading past the payload registers.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset the status word reads 0x000F (flag 0, size 0, opcode 0, state ready), the command register and every payload register read 0, and `fw_req` is low.
- R2: A host write to the command address (0) while nothing is pending, with a nonzero opcode or a nonzero size field, latches the word (flag bit 15, payload size bits 10:6, opcode bits 5:0). From the next cycle the status word is flag bit 15, size 0 in bits 14:10, opcode in bits 9:4 and state code 0x1 (received) in bits 3:0; `fw_cmd` shows the latched word and `fw_req` is high for exactly that one cycle.
- R3: An `fw_ack` while the mailbox waits for an acknowledge sets the state code to 0x2 (processing).
- R4: An `fw_done` while processing ends the command: the status keeps the echoed flag and opcode, and takes the size and code given by the firmware; the mailbox is then idle.
- R5: A command with opcode 0 and size field 0 accepted while idle is completed by the mailbox: the next status is the echoed flag, size 0, opcode 0 and state 0xF (ready), and no request reaches the firmware.
- R6: A command write while a command is pending (waiting for acknowledge or processing) is refused: the state code becomes 0xE (busy), the latched command and `fw_cmd` are unchanged, and the pending command still completes normally.
- R7: A firmware response size above 16 bytes is reported as 16 with state code 0x8 (error).
- R8: A firmware result code other than 0x4 (success), 0x8 (error) or 0xF (ready) is reported as 0x8 (error).
- R9: The eight payload registers sit at host addresses 8 to 15 (register n at 8+n) and at firmware index n. Both sides can write them, both read them back, and a firmware write wins over a host write to the same register in the same cycle.
- R10: Host writes to payload registers are ignored while a command is pending.
- R11: The status word reads at address 1. Addresses 2 to 7 read as 0 and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 4 | Host register address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for `host_addr` (combinational) |
| fw_req | output | 1 | One-cycle request: a new command awaits the firmware |
| fw_cmd | output | 16 | Latched command word |
| fw_ack | input | 1 | Firmware has taken the request |
| fw_done | input | 1 | Firmware has finished the command |
| fw_code | input | 4 | Result state code from the firmware |
| fw_len | input | 5 | Response byte count from the firmware |
| fw_dwr | input | 1 | Firmware payload register write strobe |
| fw_didx | input | 3 | Firmware payload register index |
| fw_dwdata | input | 16 | Firmware payload write data |
| fw_drdata | output | 16 | Payload register at `fw_didx` (combinational) |

## Verification
The bench sends a second command before the first is acknowledged. A mailbox that accepted it would overwrite the opcode and parity still in flight and raise a second request. It answers no-op commands without the firmware and checks that no request pulse appears, since forwarding them would leave the host's parity sync hanging. Randomly chosen response sizes and result codes, including oversize counts and transient codes, check that the reported status is always final and no larger than 16 bytes. Payload writes during a pending command and a write collision between host and firmware check that the registers are protected and that the firmware wins.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int WORD_W = 16;
    localparam int LEN_W  = 5;
    localparam int OP_W   = 6;

    typedef enum logic [3:0] {
        ST_RCVD  = 4'h1,
        ST_PROC  = 4'h2,
        ST_OK    = 4'h4,
        ST_ERR   = 4'h8,
        ST_BUSY  = 4'hE,
        ST_READY = 4'hF
    } state_code_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_WORK = 2'd2
    } phase_e;

    // Packed order matches the status word bit layout.
    typedef struct packed {
        logic             par;
        logic [LEN_W-1:0] len;
        logic [OP_W-1:0]  op;
        state_code_e      code;
    } status_t;

    // Packed order matches the command word bit layout.
    typedef struct packed {
        logic             par;
        logic [3:0]       rsvd;
        logic [LEN_W-1:0] len;
        logic [OP_W-1:0]  op;
    } cmd_t;

endpackage

// File: rtl/mbx_regfile.sv
module mbx_regfile
    import mbx_pkg::*;
#(
    parameter int NUM_DATA = 8,
    localparam int IDX_W   = $clog2(NUM_DATA)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            host_we,
    input  logic [IDX_W-1:0]                host_idx,
    input  logic [WORD_W-1:0]               host_wdata,
    input  logic                            lock,
    input  logic                            fw_we,
    input  logic [IDX_W-1:0]                fw_idx,
    input  logic [WORD_W-1:0]               fw_wdata,
    output logic [NUM_DATA-1:0][WORD_W-1:0] regs_q
);

    logic [NUM_DATA-1:0][WORD_W-1:0] regs_d;

    always_comb begin
        regs_d = regs_q;
        if (host_we && !lock) begin
            regs_d[host_idx] = host_wdata;
        end
        // firmware write applied last so it wins a collision
        if (fw_we) begin
            regs_d[fw_idx] = fw_wdata;
        end
    end

    for (genvar i = 0; i < NUM_DATA; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs_q[i] <= '0;
            end else begin
                regs_q[i] <= regs_d[i];
            end
        end
    end

    // R10
    locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && lock && !fw_we) |=> $stable(regs_q));

    // R9
    fw_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fw_we |=> (regs_q[$past(fw_idx)] == $past(fw_wdata)));

endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
    import mbx_pkg::*;
#(
    parameter int MAX_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [WORD_W-1:0] cmd_word,
    input  logic              fw_ack,
    input  logic              fw_done,
    input  logic [3:0]        fw_code,
    input  logic [LEN_W-1:0]  fw_len,
    output logic [WORD_W-1:0] status,
    output logic [WORD_W-1:0] cmd_out,
    output logic              req,
    output logic              pending
);

    typedef struct packed {
        phase_e  phase;
        status_t sts;
        cmd_t    cmd;
        logic    req;
    } ctrl_t;

    ctrl_t q, d;
    cmd_t  cmd_in;

    assign cmd_in = cmd_t'(cmd_word);

    always_comb begin
        d     = q;
        d.req = 1'b0;

        if (q.phase == PH_WAIT && fw_ack) begin
            d.phase    = PH_WORK;
            d.sts.code = ST_PROC;
        end

        if (cmd_wr) begin
            if (q.phase != PH_IDLE) begin
                d.sts.code = ST_BUSY;
            end else begin
                d.cmd     = cmd_in;
                d.sts.par = cmd_in.par;
                d.sts.op  = cmd_in.op;
                d.sts.len = '0;
                if (cmd_in.op == '0 && cmd_in.len == '0) begin
                    d.sts.code = ST_READY;
                end else begin
                    d.sts.code = ST_RCVD;
                    d.phase    = PH_WAIT;
                    d.req      = 1'b1;
                end
            end
        end

        // completion applied last: a final code overrides busy
        if (q.phase == PH_WORK && fw_done) begin
            d.phase = PH_IDLE;
            if (int'(fw_len) > MAX_BYTES) begin
                d.sts.len  = LEN_W'(MAX_BYTES);
                d.sts.code = ST_ERR;
            end else begin
                d.sts.len = fw_len;
                case (fw_code)
                    4'h4, 4'h8, 4'hF: d.sts.code = state_code_e'(fw_code);
                    default:          d.sts.code = ST_ERR;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.phase    <= PH_IDLE;
            q.sts.par  <= 1'b0;
            q.sts.len  <= '0;
            q.sts.op   <= '0;
            q.sts.code <= ST_READY;
            q.cmd      <= '0;
            q.req      <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign status  = q.sts;
    assign cmd_out = q.cmd;
    assign req     = q.req;
    assign pending = (q.phase != PH_IDLE);

    // R2
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.req |=> !q.req);

    // R3
    ack_proc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_WAIT && fw_ack && !cmd_wr) |=> (q.sts.code == ST_PROC));

    // R5
    noop_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && q.phase == PH_IDLE && cmd_word[10:0] == '0)
            |=> (q.sts.code == ST_READY && !q.req && q.phase == PH_IDLE));

    // R6
    reject_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && q.phase != PH_IDLE && !(q.phase == PH_WORK && fw_done))
            |=> (q.sts.code == ST_BUSY && $stable(q.cmd) && !q.req));

    // R7
    len_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_WORK && fw_done && int'(fw_len) > MAX_BYTES)
            |=> (int'(q.sts.len) == MAX_BYTES && q.sts.code == ST_ERR));

    // R8
    final_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_WORK && fw_done)
            |=> (q.sts.code == ST_OK || q.sts.code == ST_ERR || q.sts.code == ST_READY));

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
    import mbx_pkg::*;
#(
    parameter int NUM_DATA = 8,
    localparam int IDX_W     = $clog2(NUM_DATA),
    localparam int ADDR_W    = IDX_W + 1,
    localparam int MAX_BYTES = NUM_DATA * WORD_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [15:0]       host_wdata,
    output logic [15:0]       host_rdata,
    output logic              fw_req,
    output logic [15:0]       fw_cmd,
    input  logic              fw_ack,
    input  logic              fw_done,
    input  logic [3:0]        fw_code,
    input  logic [4:0]        fw_len,
    input  logic              fw_dwr,
    input  logic [IDX_W-1:0]  fw_didx,
    input  logic [15:0]       fw_dwdata,
    output logic [15:0]       fw_drdata
);

    localparam logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] STS_ADDR = ADDR_W'(1);

    logic                            data_hit;
    logic [IDX_W-1:0]                data_idx;
    logic                            cmd_wr;
    logic                            pending;
    logic [WORD_W-1:0]               status;
    logic [NUM_DATA-1:0][WORD_W-1:0] regs;

    assign data_hit = host_addr[ADDR_W-1];
    assign data_idx = host_addr[IDX_W-1:0];
    assign cmd_wr   = host_wr && (host_addr == CMD_ADDR);

    mbx_ctrl #(
        .MAX_BYTES(MAX_BYTES)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_wr  (cmd_wr),
        .cmd_word(host_wdata),
        .fw_ack  (fw_ack),
        .fw_done (fw_done),
        .fw_code (fw_code),
        .fw_len  (fw_len),
        .status  (status),
        .cmd_out (fw_cmd),
        .req     (fw_req),
        .pending (pending)
    );

    mbx_regfile #(
        .NUM_DATA(NUM_DATA)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_we   (host_wr && data_hit),
        .host_idx  (data_idx),
        .host_wdata(host_wdata),
        .lock      (pending),
        .fw_we     (fw_dwr),
        .fw_idx    (fw_didx),
        .fw_wdata  (fw_dwdata),
        .regs_q    (regs)
    );

    always_comb begin
        if (data_hit) begin
            host_rdata = regs[data_idx];
        end else if (host_addr == CMD_ADDR) begin
            host_rdata = fw_cmd;
        end else if (host_addr == STS_ADDR) begin
            host_rdata = status;
        end else begin
            host_rdata = '0;
        end
    end

    assign fw_drdata = regs[fw_didx];

    // R2
    req_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fw_req |-> ($past(cmd_wr) && !$past(pending)));

    // R7
    size_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(status[14:10]) <= MAX_BYTES);

endmodule

// File: tb/ipc_mailbox_tb.sv
module ipc_mailbox_tb;

    localparam int NUM_DATA = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        fw_req;
    logic [15:0] fw_cmd;
    logic        fw_ack = 1'b0;
    logic        fw_done = 1'b0;
    logic [3:0]  fw_code = '0;
    logic [4:0]  fw_len = '0;
    logic        fw_dwr = 1'b0;
    logic [2:0]  fw_didx = '0;
    logic [15:0] fw_dwdata = '0;
    logic [15:0] fw_drdata;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    logic par_t = 1'b0;

    always #4 clk = ~clk;

    ipc_mailbox #(.NUM_DATA(NUM_DATA)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata),
        .fw_req(fw_req), .fw_cmd(fw_cmd),
        .fw_ack(fw_ack), .fw_done(fw_done), .fw_code(fw_code), .fw_len(fw_len),
        .fw_dwr(fw_dwr), .fw_didx(fw_didx), .fw_dwdata(fw_dwdata),
        .fw_drdata(fw_drdata)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_chk  = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: act=hung exp=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    function automatic logic [15:0] sts_word(logic p, logic [4:0] l, logic [5:0] o, logic [3:0] c);
        return {p, l, o, c};
    endfunction

    function automatic logic [15:0] cmd_word(logic p, logic [4:0] l, logic [5:0] o);
        return {p, 4'b0, l, o};
    endfunction

    function automatic logic [4:0] exp_len(logic [4:0] l);
        return (l > 5'd16) ? 5'd16 : l;
    endfunction

    function automatic logic [3:0] exp_code(logic [3:0] c, logic [4:0] l);
        if (l > 5'd16) return 4'h8;
        if (c == 4'h4 || c == 4'h8 || c == 4'hF) return c;
        return 4'h8;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [3:0] a, input logic [15:0] v);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = v;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [3:0] a, output logic [15:0] v);
        @(negedge clk);
        host_addr = a;
        #1;
        v = host_rdata;
    endtask

    task automatic fw_ack_pulse();
        @(negedge clk);
        fw_ack = 1'b1;
        @(negedge clk);
        fw_ack = 1'b0;
    endtask

    task automatic fw_finish(input logic [3:0] c, input logic [4:0] l);
        @(negedge clk);
        fw_done = 1'b1; fw_code = c; fw_len = l;
        @(negedge clk);
        fw_done = 1'b0;
    endtask

    task automatic fw_write(input logic [2:0] i, input logic [15:0] v);
        @(negedge clk);
        fw_dwr = 1'b1; fw_didx = i; fw_dwdata = v;
        @(negedge clk);
        fw_dwr = 1'b0;
    endtask

    // sends a command with the current parity, returns the parity used
    task automatic send_cmd(input logic [5:0] op, input logic [4:0] l, output logic p);
        p = par_t;
        host_write(4'd0, cmd_word(p, l, op));
        par_t = ~par_t;
    endtask

    logic [15:0] rd;
    logic        p0, p1;
    logic [3:0]  codes [7];

    initial begin
        codes[0] = 4'h4; codes[1] = 4'h8; codes[2] = 4'hF; codes[3] = 4'h1;
        codes[4] = 4'h2; codes[5] = 4'hE; codes[6] = 4'h3;
        void'($urandom(32'h1f2e3d4c));

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        host_read(4'd1, rd); check("R1 status", rd, 16'h000F);
        host_read(4'd0, rd); check("R1 command", rd, 16'h0000);
        host_read(4'd8, rd); check("R1 data0", rd, 16'h0000);
        check("R1 fw_req", {15'b0, fw_req}, 16'h0000);

        // R5 no-op completes locally, parity sync sequence
        send_cmd(6'd0, 5'd0, p0);
        check("R5 fw_req", {15'b0, fw_req}, 16'h0000);
        host_read(4'd1, rd); check("R5 status", rd, sts_word(p0, 5'd0, 6'd0, 4'hF));
        send_cmd(6'd0, 5'd0, p0);
        host_read(4'd1, rd); check("R5 status parity", rd, sts_word(p0, 5'd0, 6'd0, 4'hF));

        // R11 unmapped addresses
        host_write(4'd2, 16'hBEEF);
        host_read(4'd2, rd); check("R11 addr2", rd, 16'h0000);
        host_read(4'd7, rd); check("R11 addr7", rd, 16'h0000);
        host_read(4'd1, rd); check("R11 status intact", rd, sts_word(p0, 5'd0, 6'd0, 4'hF));

        // R9 version query: payload passes to firmware, string returned
        host_write(4'd8, 16'h0001);
        fw_didx = 3'd0; #1;
        check("R9 fw reads payload", fw_drdata, 16'h0001);
        send_cmd(6'd1, 5'd2, p0);
        check("R2 fw_req", {15'b0, fw_req}, 16'h0001);
        check("R2 fw_cmd", fw_cmd, cmd_word(p0, 5'd2, 6'd1));
        host_read(4'd1, rd); check("R2 status", rd, sts_word(p0, 5'd0, 6'd1, 4'h1));
        check("R2 single pulse", {15'b0, fw_req}, 16'h0000);
        fw_ack_pulse();
        host_read(4'd1, rd); check("R3 status", rd, sts_word(p0, 5'd0, 6'd1, 4'h2));
        fw_write(3'd0, 16'h3176);  // "v1"
        fw_write(3'd1, 16'h322E);  // ".2"
        fw_write(3'd2, 16'h332E);  // ".3"
        fw_finish(4'h4, 5'd6);
        host_read(4'd1, rd); check("R4 version status", rd, sts_word(p0, 5'd6, 6'd1, 4'h4));
        host_read(4'd8, rd);  check("R9 ver word0", rd, 16'h3176);
        host_read(4'd9, rd);  check("R9 ver word1", rd, 16'h322E);
        host_read(4'd10, rd); check("R9 ver word2", rd, 16'h332E);

        // R6 second command while first pending
        send_cmd(6'd5, 5'd4, p0);
        send_cmd(6'd9, 5'd2, p1);
        host_read(4'd1, rd); check("R6 busy", rd, sts_word(p0, 5'd0, 6'd5, 4'hE));
        check("R6 fw_cmd kept", fw_cmd, cmd_word(p0, 5'd4, 6'd5));
        check("R6 no new req", {15'b0, fw_req}, 16'h0000);
        // R10 payload locked while pending
        host_write(4'd11, 16'hAAAA);
        host_read(4'd11, rd); check("R10 locked", rd, 16'h0000);
        fw_ack_pulse();
        host_read(4'd1, rd); check("R3 after busy", rd, sts_word(p0, 5'd0, 6'd5, 4'h2));
        fw_finish(4'h4, 5'd2);
        host_read(4'd1, rd); check("R6 original completes", rd, sts_word(p0, 5'd2, 6'd5, 4'h4));

        // R7 oversize response
        send_cmd(6'd26, 5'd4, p0);
        fw_ack_pulse();
        fw_finish(4'h4, 5'd31);
        host_read(4'd1, rd); check("R7 clamp", rd, sts_word(p0, 5'd16, 6'd26, 4'h8));

        // R8 transient code written back
        send_cmd(6'd21, 5'd0, p0);
        fw_ack_pulse();
        fw_finish(4'hE, 5'd2);
        host_read(4'd1, rd); check("R8 transient to error", rd, sts_word(p0, 5'd2, 6'd21, 4'h8));

        // R9 firmware wins a same-cycle collision
        @(negedge clk);
        host_wr = 1'b1; host_addr = 4'd12; host_wdata = 16'h1111;
        fw_dwr = 1'b1; fw_didx = 3'd4; fw_dwdata = 16'h2222;
        @(negedge clk);
        host_wr = 1'b0; fw_dwr = 1'b0;
        host_read(4'd12, rd); check("R9 collision", rd, 16'h2222);

        // constrained random commands
        for (int it = 0; it < 40; it++) begin
            logic [5:0]  op;
            logic [4:0]  l;
            logic [3:0]  c;
            logic [4:0]  fl;
            logic [2:0]  di;
            logic [15:0] dv;
            op = 6'($urandom_range(1, 63));
            l  = 5'($urandom_range(0, 16));
            c  = codes[$urandom_range(0, 6)];
            fl = 5'($urandom_range(0, 31));
            di = 3'($urandom_range(0, 7));
            dv = 16'($urandom);
            host_write(4'(8 + di), dv);
            host_read(4'(8 + di), rd); check("R9 random host data", rd, dv);
            send_cmd(op, l, p0);
            check("R2 random req", {15'b0, fw_req}, 16'h0001);
            host_read(4'd1, rd); check("R2 random status", rd, sts_word(p0, 5'd0, op, 4'h1));
            fw_ack_pulse();
            host_read(4'd1, rd); check("R3 random", rd, sts_word(p0, 5'd0, op, 4'h2));
            dv = ~dv;
            fw_write(di, dv);
            fw_finish(c, fl);
            host_read(4'd1, rd);
            check("R4 R7 R8 random final", rd, sts_word(p0, exp_len(fl), op, exp_code(c, fl)));
            host_read(4'(8 + di), rd); check("R9 random fw data", rd, dv);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule